// File: doc/BRIEF.md
# Logarithmic Attenuation Code Decoder

This block turns an 8-bit attenuation setting, written over a simple parallel port with an active-low select and an active-low write strobe, into a 17-bit linear gain word for a binary-weighted multiplying converter. Each unit of the code is a fixed 0.375 dB of attenuation. The code splits into two nibbles. The low nibble picks one of sixteen fine mantissas, each 0.375 dB below the one before it. The high nibble shifts the chosen mantissa right by one bit per count, which adds about 6 dB per count. When the high nibble is all ones, the output is forced to zero to mute the signal.

The parameter `LATCH_MODE` sets how the input latch behaves. In edge mode, a write is taken on the rising edge of the strobe. The block then reports busy for a programmable refresh interval, and the new gain word is presented when that interval ends. In level mode, the latch is transparent while select and strobe are both low, and the gain word follows the bus one register later. Select, strobe and data all pass through the same synchronizer chain, so they stay aligned with one another. The port has no back-pressure: a write that arrives while busy is high is dropped, and the writer is expected to watch busy before it writes.

Top module: `log_atten_decoder`

## Requirements
- R1: For a code N below 240, the gain word equals M(N mod 16) shifted right by N div 16. Here M(k) = round(2^17 · 10^(-0.375·k/20)), limited to 131071. The low nibble is bits 3:0 and the high nibble is bits 7:4.
- R2: Code 0 produces the full-scale word 131071.
- R3: Every code from 240 to 255 (high nibble 1111) produces the word 0.
- R4: Over codes 0 through 255, the gain word never increases as the code increases.
- R5: In edge mode, a write is taken only when the strobe rises while select is low. A strobe pulse while select is high changes neither busy nor the gain word.
- R6: In edge mode, the gain word keeps its old value while busy is high. It takes the new value on the same clock edge where busy falls.
- R7: Each accepted edge-mode write holds busy high for exactly REFRESH_CYC clock cycles. Strobes that arrive while busy is high are ignored.
- R8: In level mode, the gain word follows the bus while select and strobe are both low. It holds once either of them goes high. Busy is never asserted in this mode.
- R9: Reset loads the mute code 0xF0, so the gain word is 0 and busy is low until the first write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select, asynchronous to clk |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| data | input | 8 | Attenuation code, 0.375 dB per unit |
| busy | output | 1 | High while an edge-mode write is still settling |
| gain | output | 17 | Linear gain word for the converter; 0 means mute |

## Verification
The bench builds two copies of the block at the default 8-bit code and 17-bit gain widths. One copy is in edge mode and the other in level mode, and both use a refresh interval of 8 cycles in place of the long default. The short interval makes it cheap to write every one of the 256 codes through each copy. That full sweep covers both nibble boundaries, the full-scale code and the whole mute region, and it allows monotonicity to be checked across the entire code space. It also puts the busy window, dropped writes during busy, and holds against a raised select or strobe in reach within a few cycles each.

// File: rtl/log_atten_pkg.sv
package log_atten_pkg;

  typedef enum logic {
    LATCH_EDGE  = 1'b0,
    LATCH_LEVEL = 1'b1
  } latch_mode_e;

  // Fine-step mantissa for low-nibble value k, rounded and limited to full scale.
  function automatic int fine_mant(input int k, input int gain_w, input int step_mdb);
    real full;
    real db;
    real lin;
    int  v;
    full = 2.0 ** gain_w;
    db   = real'(step_mdb * k) / 1000.0;
    lin  = full * (10.0 ** (-db / 20.0));
    v    = $rtoi(lin + 0.5);
    if (v > (1 << gain_w) - 1) v = (1 << gain_w) - 1;
    return v;
  endfunction

endpackage

// File: rtl/lad_sync.sv
module lad_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lad_capture.sv
module lad_capture
  import log_atten_pkg::*;
#(
  parameter int               CODE_W      = 8,
  parameter latch_mode_e      LATCH_MODE  = LATCH_EDGE,
  parameter int               REFRESH_CYC = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              wr_n_s,
  input  logic [CODE_W-1:0] data_s,
  output logic [CODE_W-1:0] code,
  output logic              load,
  output logic              busy
);

  localparam int CNT_W = $clog2(REFRESH_CYC + 1);

  generate
    if (LATCH_MODE == LATCH_EDGE) begin : g_edge
      logic             wr_prev;
      logic [CNT_W-1:0] cnt;
      logic             accept;

      assign accept = wr_n_s && !wr_prev && !cs_n_s && (cnt == '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_prev <= 1'b1;
          cnt     <= '0;
          code    <= RESET_CODE;
        end else begin
          wr_prev <= wr_n_s;
          if (accept) begin
            code <= data_s;
            cnt  <= CNT_W'(REFRESH_CYC);
          end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      end

      assign busy = (cnt != '0);
      assign load = (cnt == CNT_W'(1));
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code <= RESET_CODE;
        else if (!cs_n_s && !wr_n_s) code <= data_s;
      end

      assign busy = 1'b0;
      assign load = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/lad_gain_decode.sv
module lad_gain_decode #(
  parameter int CODE_W   = 8,
  parameter int GAIN_W   = 17,
  parameter int STEP_MDB = 375
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              load,
  output logic [GAIN_W-1:0] gain
);

  localparam int NIB_W  = CODE_W / 2;
  localparam int FINE_N = 1 << NIB_W;

  logic [GAIN_W-1:0] mant_tab [FINE_N];
  logic [NIB_W-1:0]  hi;
  logic [NIB_W-1:0]  lo;
  logic [GAIN_W-1:0] next_gain;

  generate
    for (genvar k = 0; k < FINE_N; k++) begin : g_mant
      localparam int MV = log_atten_pkg::fine_mant(k, GAIN_W, STEP_MDB);
      assign mant_tab[k] = GAIN_W'(MV);
    end
  endgenerate

  assign hi = code[CODE_W-1 -: NIB_W];
  assign lo = code[NIB_W-1:0];

  always_comb begin
    if (&hi) next_gain = '0;
    else     next_gain = mant_tab[lo] >> hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gain <= '0;
    else if (load) gain <= next_gain;
  end

endmodule

// File: rtl/log_atten_decoder.sv
module log_atten_decoder
  import log_atten_pkg::*;
#(
  parameter int          CODE_W      = 8,
  parameter int          GAIN_W      = 17,
  parameter int          STEP_MDB    = 375,
  parameter latch_mode_e LATCH_MODE  = LATCH_EDGE,
  parameter int          REFRESH_CYC = 300,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] data,
  output logic              busy,
  output logic [GAIN_W-1:0] gain
);

  localparam int                BUS_W      = CODE_W + 2;
  localparam logic [CODE_W-1:0] MUTE_CODE  = {{(CODE_W/2){1'b1}}, {(CODE_W - CODE_W/2){1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic [CODE_W-1:0] code;
  logic              load;

  lad_sync #(
    .W       (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({2'b11, {CODE_W{1'b0}}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, wr_n, data}),
    .q     (bus_s)
  );

  lad_capture #(
    .CODE_W      (CODE_W),
    .LATCH_MODE  (LATCH_MODE),
    .REFRESH_CYC (REFRESH_CYC),
    .RESET_CODE  (MUTE_CODE)
  ) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_s (bus_s[BUS_W-1]),
    .wr_n_s (bus_s[BUS_W-2]),
    .data_s (bus_s[CODE_W-1:0]),
    .code   (code),
    .load   (load),
    .busy   (busy)
  );

  lad_gain_decode #(
    .CODE_W   (CODE_W),
    .GAIN_W   (GAIN_W),
    .STEP_MDB (STEP_MDB)
  ) u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code),
    .load  (load),
    .gain  (gain)
  );

endmodule

// File: rtl/log_atten_decoder_chk.sv
module log_atten_decoder_chk
  import log_atten_pkg::*;
#(
  parameter int          GAIN_W      = 17,
  parameter latch_mode_e LATCH_MODE  = LATCH_EDGE,
  parameter int          REFRESH_CYC = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [GAIN_W-1:0] gain
);

  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 32'd1;
    else           run <= '0;
  end

  // R7: busy window length per accepted write
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 32'(REFRESH_CYC)));

  // R6: in edge mode the gain word only moves as busy falls
  a_r6_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((LATCH_MODE == LATCH_EDGE) && !$fell(busy)) |-> $stable(gain));

  // R8: level mode never reports busy
  a_r8_level_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCH_MODE == LATCH_LEVEL) |-> !busy);

  // R9: first cycle out of reset is muted and idle
  a_r9_reset_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (gain == '0 && !busy));

endmodule

bind log_atten_decoder log_atten_decoder_chk #(
  .GAIN_W      (GAIN_W),
  .LATCH_MODE  (LATCH_MODE),
  .REFRESH_CYC (REFRESH_CYC)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .gain  (gain)
);

// File: tb/test_log_atten_decoder.sv
`timescale 1ns/1ps
module test_log_atten_decoder;
  import log_atten_pkg::*;

  localparam int REFRESH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e_cs_n = 1'b1, e_wr_n = 1'b1;
  logic [7:0]  e_data = 8'h00;
  logic        e_busy;
  logic [16:0] e_gain;
  logic        l_cs_n = 1'b1, l_wr_n = 1'b1;
  logic [7:0]  l_data = 8'h00;
  logic        l_busy;
  logic [16:0] l_gain;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  log_atten_decoder #(.LATCH_MODE(LATCH_EDGE), .REFRESH_CYC(REFRESH)) i_log_atten_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(e_cs_n), .wr_n(e_wr_n), .data(e_data),
    .busy(e_busy), .gain(e_gain));

  log_atten_decoder #(.LATCH_MODE(LATCH_LEVEL), .REFRESH_CYC(REFRESH)) i_log_atten_decoder_lvl (
    .clk(clk), .rst_n(rst_n), .cs_n(l_cs_n), .wr_n(l_wr_n), .data(l_data),
    .busy(l_busy), .gain(l_gain));

  function automatic logic [16:0] exp_gain(input int n);
    int  m;
    real lin;
    if (n >= 240) return 17'd0;
    lin = 131072.0 * (10.0 ** (-0.375 * real'(n % 16) / 20.0));
    m = $rtoi(lin + 0.5);
    if (m > 131071) m = 131071;
    return 17'(m >> (n / 16));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edge-mode write; returns the number of cycles busy was seen high.
  task automatic edge_write(input logic [7:0] code, input bit sel, output int bcnt);
    bcnt = 0;
    @(negedge clk);
    e_data = code; e_cs_n = !sel; e_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    e_wr_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (e_busy) bcnt++;
      else if (bcnt > 0) break;
    end
    e_cs_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int          bc;
    logic [16:0] prev;
    logic [16:0] held;
    bit          seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state in both modes
    check(e_gain == 17'd0, "R9 edge gain after reset", e_gain, 0);
    check(e_busy == 1'b0,  "R9 edge busy after reset", e_busy, 0);
    check(l_gain == 17'd0, "R9 level gain after reset", l_gain, 0);

    // R1 R2 R3 R4 R7: sweep every code through the edge-mode copy
    prev = 17'h1FFFF;
    for (int n = 0; n < 256; n++) begin
      edge_write(8'(n), 1'b1, bc);
      check(e_gain == exp_gain(n), (n == 0) ? "R2 full scale" : (n >= 240) ? "R3 mute" : "R1 decode",
            e_gain, exp_gain(n));
      check(bc == REFRESH, "R7 busy length", bc, REFRESH);
      check(e_gain <= prev, "R4 monotonic", e_gain, prev);
      prev = e_gain;
    end

    // R5: strobe with select high is ignored
    edge_write(8'h10, 1'b1, bc);
    held = e_gain;
    edge_write(8'h33, 1'b0, bc);
    repeat (10) @(negedge clk);
    check(bc == 0, "R5 no busy with select high", bc, 0);
    check(e_gain == held, "R5 gain kept with select high", e_gain, held);

    // R6 R7: strobe during busy is dropped; gain held until busy falls
    @(negedge clk);
    e_data = 8'h24; e_cs_n = 1'b0; e_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    e_wr_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      seen = e_busy;
    end
    check(e_gain == held, "R6 gain held while busy", e_gain, held);
    e_data = 8'h05; e_wr_n = 1'b0;
    @(negedge clk);
    e_wr_n = 1'b1;
    repeat (30) @(negedge clk);
    e_cs_n = 1'b1;
    check(e_gain == exp_gain(8'h24), "R7 write during busy dropped", e_gain, exp_gain(8'h24));
    check(e_busy == 1'b0, "R7 no second busy window", e_busy, 0);

    // R8: level mode transparent sweep
    l_cs_n = 1'b0; l_wr_n = 1'b0;
    prev = 17'h1FFFF;
    for (int n = 0; n < 256; n++) begin
      @(negedge clk);
      l_data = 8'(n);
      repeat (5) @(negedge clk);
      check(l_gain == exp_gain(n), "R8 level follows bus", l_gain, exp_gain(n));
      check(l_gain <= prev, "R4 monotonic level", l_gain, prev);
      check(l_busy == 1'b0, "R8 level never busy", l_busy, 0);
      prev = l_gain;
    end
    l_data = 8'h05;
    repeat (5) @(negedge clk);
    l_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    l_data = 8'h00;
    repeat (6) @(negedge clk);
    check(l_gain == exp_gain(5), "R8 hold on strobe high", l_gain, exp_gain(5));
    l_wr_n = 1'b0; l_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(l_gain == exp_gain(5), "R8 hold on select high", l_gain, exp_gain(5));
    l_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    check(l_gain == exp_gain(0), "R8 reopen follows bus", l_gain, exp_gain(0));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule